// File: doc/BRIEF.md
# Banked Dual Stack Pointer Unit

This block keeps two 32-bit stack pointers for a processor core. One serves the interrupt stack (index 0) and one serves the user stack (index 1). A select flag chooses which pointer is active. The block holds this flag itself. Software writes it through a write strobe that mirrors the status register. An interrupt or trap entry clears it, so that the next stack accesses land on the interrupt stack. Stacks grow toward lower addresses, and each pointer always names the lowest byte of the newest item. A push moves the active pointer down by the operand length and then uses the new value as the write address. A pop uses the current value as the read address and then moves the pointer up.

The pipeline that issues stack accesses drives push or pop strobes with a 2-bit length code. In the same cycle it reads back the access address, a qualifier for that address, and an error flag. The updated pointer values appear after the next rising clock edge. An explicit load port writes either pointer by index, for context switches and initialisation. The block has no back-pressure: every legal request is accepted in the cycle it is presented, and `addr_valid_o` acts as the valid of the address stream, with an implicit ready that is always high. Memory access, instruction decode and the frame pointer live elsewhere.

Top module: `stkptr_unit`

## Requirements
- R1: After reset both pointers read 0 and the select flag reads 0.
- R2: The active pointer is pointer 0 (interrupt stack) when the effective select is 0 and pointer 1 (user stack) when it is 1. The inactive pointer never changes because of a push or pop.
- R3: A push (push_i=1, pop_i=0, legal length, no load) makes `mem_addr_o` equal to the active pointer minus the length in the same cycle, raises `addr_valid_o`, and leaves that value in the active pointer after the next edge. Length code 2'b00 is 1 byte, 2'b01 is 2 bytes and 2'b10 is 4 bytes.
- R4: A pop (pop_i=1, push_i=0, legal length, no load) makes `mem_addr_o` equal to the active pointer in the same cycle, raises `addr_valid_o`, and adds the length to the active pointer at the next edge.
- R5: Length code 2'b11 with a push or pop raises `err_o` in that cycle, keeps `addr_valid_o` low and leaves both pointers unchanged.
- R6: A push and a pop asserted together raise `err_o` in that cycle, keep `addr_valid_o` low and leave both pointers unchanged.
- R7: A trap entry strobe clears the select flag at the next edge. A push or pop in the same cycle as the strobe already uses pointer 0.
- R8: `sel_wr_i` loads `sel_val_i` into the select flag at the next edge. A trap entry in the same cycle wins, and the flag becomes 0.
- R9: `load_en_i` writes `load_val_i` into the pointer named by `load_idx_i` (0 = interrupt, 1 = user) at the next edge, whatever the select flag is. A push or pop in the same cycle is dropped: no address valid, no error, and no other pointer change.
- R10: Pointer arithmetic wraps modulo 2^32 in both directions.
- R11: In a cycle with no push, pop or load, `addr_valid_o` and `err_o` are low, `mem_addr_o` is 0, and neither pointer changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Push request strobe |
| pop_i | input | 1 | Pop request strobe |
| len_code_i | input | 2 | Operand length code (00=1, 01=2, 10=4 bytes, 11 illegal) |
| sel_wr_i | input | 1 | Write strobe for the select flag |
| sel_val_i | input | 1 | New select flag value (0 interrupt, 1 user) |
| trap_entry_i | input | 1 | Interrupt or trap entry strobe |
| load_en_i | input | 1 | Explicit pointer load strobe |
| load_idx_i | input | 1 | Pointer index for a load |
| load_val_i | input | 32 | Value to load |
| mem_addr_o | output | 32 | Address of the current stack access |
| addr_valid_o | output | 1 | Access address is valid this cycle |
| err_o | output | 1 | Illegal request this cycle (conflict or bad length) |
| sel_o | output | 1 | Current select flag |
| sp_int_o | output | 32 | Interrupt stack pointer value |
| sp_usr_o | output | 32 | User stack pointer value |

## Verification
The assertions assume that all inputs are 2-state and settle well before each rising edge. They also assume that `load_idx_i`, `len_code_i` and `sel_val_i` matter only while their strobes are high. The bench changes every input once per cycle on the falling edge and always drives known values, including on idle cycles. The random phase mixes in conflicting strobes, the illegal length code, trap strobes that coincide with select writes, and loads that collide with pushes or pops. Directed sequences first drive the pointers to values next to 0 and to 2^32, so that the wrap cases are certain to occur.

// File: rtl/stkptr_pkg.sv
package stkptr_pkg;
  localparam int unsigned LEN_BYTES_W = 3;

  typedef enum logic [1:0] {
    LEN_BYTE = 2'b00,
    LEN_HALF = 2'b01,
    LEN_WORD = 2'b10,
    LEN_BAD  = 2'b11
  } len_code_e;

  localparam logic IDX_INT = 1'b0;
  localparam logic IDX_USR = 1'b1;
endpackage

// File: rtl/stkptr_len_decode.sv
module stkptr_len_decode
  import stkptr_pkg::*;
(
  input  logic [1:0]             code_i,
  output logic [LEN_BYTES_W-1:0] bytes_o,
  output logic                   legal_o
);
  always_comb begin
    legal_o = 1'b1;
    case (code_i)
      LEN_BYTE: bytes_o = LEN_BYTES_W'(1);
      LEN_HALF: bytes_o = LEN_BYTES_W'(2);
      LEN_WORD: bytes_o = LEN_BYTES_W'(4);
      default: begin
        bytes_o = '0;
        legal_o = 1'b0;
      end
    endcase
  end

  always_comb begin
    if (legal_o) assert_len_nonzero_R3: assert (bytes_o != '0);
  end
endmodule

// File: rtl/stkptr_addr_calc.sv
module stkptr_addr_calc
  import stkptr_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0]          base_i,
  input  logic [LEN_BYTES_W-1:0] bytes_i,
  input  logic                   is_push_i,
  output logic [AW-1:0]          addr_o,
  output logic [AW-1:0]          next_o
);
  localparam int unsigned PAD_W = AW - LEN_BYTES_W;

  logic [AW-1:0] len_ext;
  logic [AW-1:0] dec_val;
  logic [AW-1:0] inc_val;

  assign len_ext = {{PAD_W{1'b0}}, bytes_i};
  assign dec_val = base_i - len_ext;
  assign inc_val = base_i + len_ext;

  always_comb begin
    if (is_push_i) begin
      addr_o = dec_val;
      next_o = dec_val;
    end else begin
      addr_o = base_i;
      next_o = inc_val;
    end
  end
endmodule

// File: rtl/stkptr_sel_reg.sv
module stkptr_sel_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic trap_i,
  input  logic wr_i,
  input  logic val_i,
  output logic sel_o,
  output logic eff_o
);
  logic sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= 1'b0;
    else if (trap_i) sel_q <= 1'b0;
    else if (wr_i)   sel_q <= val_i;
  end

  assign sel_o = sel_q;
  assign eff_o = trap_i ? 1'b0 : sel_q;

  assert_trap_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> !sel_o);

  assert_sel_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !trap_i) |=> (sel_o == $past(val_i)));
endmodule

// File: rtl/stkptr_ptr_bank.sv
module stkptr_ptr_bank #(
  parameter int unsigned AW    = 32,
  parameter int unsigned N_PTR = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en_i,
  input  logic [$clog2(N_PTR)-1:0]    wr_idx_i,
  input  logic [AW-1:0]               wr_val_i,
  output logic [N_PTR-1:0][AW-1:0]    sp_o
);
  localparam int unsigned IW = $clog2(N_PTR);

  for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
    logic hit;
    assign hit = wr_en_i && (wr_idx_i == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sp_o[g] <= '0;
      else if (hit) sp_o[g] <= wr_val_i;
    end
  end

  assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (sp_o[$past(wr_idx_i)] == $past(wr_val_i)));
endmodule

// File: rtl/stkptr_unit.sv
module stkptr_unit
  import stkptr_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [1:0]    len_code_i,
  input  logic          sel_wr_i,
  input  logic          sel_val_i,
  input  logic          trap_entry_i,
  input  logic          load_en_i,
  input  logic          load_idx_i,
  input  logic [AW-1:0] load_val_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          addr_valid_o,
  output logic          err_o,
  output logic          sel_o,
  output logic [AW-1:0] sp_int_o,
  output logic [AW-1:0] sp_usr_o
);
  localparam int unsigned N_PTR = 2;

  logic                        eff_sel;
  logic [LEN_BYTES_W-1:0]      len_bytes;
  logic                        len_legal;
  logic [N_PTR-1:0][AW-1:0]    sp;
  logic [AW-1:0]               active;
  logic [AW-1:0]               acc_addr;
  logic [AW-1:0]               next_val;
  logic                        any_req;
  logic                        one_req;
  logic                        req_ok;
  logic                        wr_en;
  logic                        wr_idx;
  logic [AW-1:0]               wr_val;

  stkptr_sel_reg u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .trap_i(trap_entry_i),
    .wr_i  (sel_wr_i),
    .val_i (sel_val_i),
    .sel_o (sel_o),
    .eff_o (eff_sel)
  );

  stkptr_len_decode u_len (
    .code_i (len_code_i),
    .bytes_o(len_bytes),
    .legal_o(len_legal)
  );

  assign active = sp[eff_sel];

  stkptr_addr_calc #(.AW(AW)) u_calc (
    .base_i   (active),
    .bytes_i  (len_bytes),
    .is_push_i(push_i),
    .addr_o   (acc_addr),
    .next_o   (next_val)
  );

  assign any_req = push_i | pop_i;
  assign one_req = push_i ^ pop_i;
  assign req_ok  = one_req && len_legal && !load_en_i;

  assign err_o        = !load_en_i && ((push_i && pop_i) || (any_req && !len_legal));
  assign addr_valid_o = req_ok;
  assign mem_addr_o   = req_ok ? acc_addr : '0;

  assign wr_en  = load_en_i || req_ok;
  assign wr_idx = load_en_i ? load_idx_i : eff_sel;
  assign wr_val = load_en_i ? load_val_i : next_val;

  stkptr_ptr_bank #(.AW(AW), .N_PTR(N_PTR)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_en),
    .wr_idx_i(wr_idx),
    .wr_val_i(wr_val),
    .sp_o    (sp)
  );

  assign sp_int_o = sp[IDX_INT];
  assign sp_usr_o = sp[IDX_USR];

  assert_push_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid_o && push_i) |=>
      (($past(eff_sel) ? sp_usr_o : sp_int_o) == $past(mem_addr_o)));

  assert_pop_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid_o && pop_i) |-> (mem_addr_o == (eff_sel ? sp_usr_o : sp_int_o)));

  assert_bad_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (one_req && len_code_i == LEN_BAD && !load_en_i) |-> (err_o && !addr_valid_o));

  assert_conflict_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && !load_en_i) |=> ($stable(sp_int_o) && $stable(sp_usr_o)));

  assert_trap_uses_int_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_entry_i && addr_valid_o && !load_en_i) |=> $stable(sp_usr_o));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && !pop_i && !load_en_i) |=>
      ($stable(sp_int_o) && $stable(sp_usr_o)));

  assert_inactive_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en_i && !eff_sel) |=> $stable(sp_usr_o));
endmodule

// File: tb/tb_stkptr_unit.sv
module tb_stkptr_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 0, pop_i = 0, sel_wr_i = 0, sel_val_i = 0;
  logic        trap_entry_i = 0, load_en_i = 0, load_idx_i = 0;
  logic [1:0]  len_code_i = 0;
  logic [31:0] load_val_i = 0;
  logic [31:0] mem_addr_o, sp_int_o, sp_usr_o;
  logic        addr_valid_o, err_o, sel_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] m_sp [2];
  logic        m_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  stkptr_unit dut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
    .len_code_i(len_code_i), .sel_wr_i(sel_wr_i), .sel_val_i(sel_val_i),
    .trap_entry_i(trap_entry_i), .load_en_i(load_en_i), .load_idx_i(load_idx_i),
    .load_val_i(load_val_i), .mem_addr_o(mem_addr_o), .addr_valid_o(addr_valid_o),
    .err_o(err_o), .sel_o(sel_o), .sp_int_o(sp_int_o), .sp_usr_o(sp_usr_o)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // One cycle: drive on falling edge, check same-cycle outputs, then the state after the edge.
  task automatic step(input logic pu, input logic po, input logic [1:0] lc,
                      input logic sw, input logic sv, input logic tr,
                      input logic ld, input logic li, input logic [31:0] lv,
                      input string reg_tag);
    logic        eff, legal, ok, e_err;
    logic [31:0] lenb, act_p, e_addr, nxt;
    string       tg;
    @(negedge clk);
    push_i = pu; pop_i = po; len_code_i = lc; sel_wr_i = sw; sel_val_i = sv;
    trap_entry_i = tr; load_en_i = ld; load_idx_i = li; load_val_i = lv;
    #1;
    eff   = tr ? 1'b0 : m_sel;
    legal = (lc != 2'b11);
    lenb  = (lc == 2'b00) ? 32'd1 : (lc == 2'b01) ? 32'd2 : 32'd4;
    ok    = (pu ^ po) && legal && !ld;
    e_err = !ld && ((pu && po) || ((pu || po) && !legal));
    act_p = m_sp[eff];
    e_addr = ok ? (pu ? act_p - lenb : act_p) : 32'd0;
    nxt   = pu ? act_p - lenb : act_p + lenb;
    if (ld && (pu || po))   tg = "R9";
    else if (pu && po)      tg = "R6";
    else if (pu || po) begin
      if (!legal)           tg = "R5";
      else if (tr)          tg = "R7";
      else if (pu)          tg = "R3";
      else                  tg = "R4";
    end else                tg = "R11";
    chk({31'd0, addr_valid_o}, {31'd0, ok}, tg, "addr_valid_o");
    chk({31'd0, err_o}, {31'd0, e_err}, tg, "err_o");
    chk(mem_addr_o, e_addr, tg, "mem_addr_o");
    @(posedge clk);
    if (ld)      m_sp[li] = lv;
    else if (ok) m_sp[eff] = nxt;
    if (tr)      m_sel = 1'b0;
    else if (sw) m_sel = sv;
    #1;
    chk(sp_int_o, m_sp[0], reg_tag, "sp_int_o");
    chk(sp_usr_o, m_sp[1], reg_tag, "sp_usr_o");
    chk({31'd0, sel_o}, {31'd0, m_sel}, tr ? "R7" : (sw ? "R8" : reg_tag), "sel_o");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    m_sp[0] = '0; m_sp[1] = '0; m_sel = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(sp_int_o, 32'd0, "R1", "sp_int_o");
    chk(sp_usr_o, 32'd0, "R1", "sp_usr_o");
    chk({31'd0, sel_o}, 32'd0, "R1", "sel_o");
    @(negedge clk); rst_n = 1'b1;

    // R10: wrap downward from 0 with a word push on the interrupt stack
    step(1, 0, 2'b10, 0, 0, 0, 0, 0, 0, "R10");
    chk(sp_int_o, 32'hFFFF_FFFC, "R10", "wrap down");
    // R10: wrap upward from the top with a halfword pop
    step(0, 0, 2'b00, 0, 0, 0, 1, 0, 32'hFFFF_FFFF, "R9");
    step(0, 1, 2'b01, 0, 0, 0, 0, 0, 0, "R10");
    chk(sp_int_o, 32'd1, "R10", "wrap up");
    // R8 / R2: switch to the user stack, push byte, then a halfword
    step(0, 0, 2'b00, 1, 1, 0, 0, 0, 0, "R8");
    step(0, 0, 2'b00, 0, 0, 0, 1, 1, 32'h0000_1000, "R9");
    step(1, 0, 2'b00, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 0, 2'b01, 0, 0, 0, 0, 0, 0, "R3");
    step(0, 1, 2'b10, 0, 0, 0, 0, 0, 0, "R4");
    // R7: trap together with a push uses the interrupt stack, and beats a select write
    step(1, 0, 2'b10, 1, 1, 1, 0, 0, 0, "R7");
    // R9: load into the user pointer while the interrupt one is active, with a colliding pop
    step(0, 1, 2'b00, 0, 0, 0, 1, 1, 32'hDEAD_BEE0, "R9");
    // R5, R6, R11
    step(1, 0, 2'b11, 0, 0, 0, 0, 0, 0, "R5");
    step(1, 1, 2'b00, 0, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 2'b00, 0, 0, 0, 0, 0, 0, "R11");

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[2:0] < 3, (r[5:3] < 3) || (r[5:3] == 7 && r[2:0] < 3), r[7:6],
           r[10:8] == 0, r[11], r[15:12] == 0, r[19:16] == 0, r[20],
           $urandom, "R2");
    end
    done = 1;
    finish_run();
  end
endmodule